// File: doc/BRIEF.md
# Carry-Select Adder/Subtractor

This block adds or subtracts two 16-bit two's-complement operands in purely combinational logic. The operand width is cut into equal sections of four bits. Every section forms per-bit generate (`a AND b`) and propagate (`a OR b`) terms. From these it runs two carry chains side by side: one assumes a carry of 0 enters the section and the other assumes a carry of 1. Once the real carry reaches the section, a multiplexer passes on the matching sum bits and section carry-out. The section carries link from the least significant section up to the most significant one.

A single mode input picks addition or subtraction. For subtraction, the second operand is bit-inverted and the carry into bit 0 is set to 1, which adds the two's-complement negative. For addition that carry is 0. The block drives three outputs: the result, the carry out of the top bit, and a signed-overflow flag. The flag is the XOR of the carry into the top bit and the carry out of it. A datapath uses the block directly between its operand registers and its result register.

Top module: `csel_addsub`

## Requirements
- R1: With `sub_i` = 0, `res_o` equals (`opa_i` + `opb_i`) modulo 2^16.
- R2: With `sub_i` = 1, `res_o` equals (`opa_i` − `opb_i`) modulo 2^16.
- R3: With `sub_i` = 0, `cout_o` is bit 16 of the unsigned 17-bit sum of the operands.
- R4: With `sub_i` = 1, `cout_o` is 1 exactly when `opa_i` ≥ `opb_i` as unsigned numbers. A value of 0 means a borrow.
- R5: `ovf_o` is 1 exactly when the true signed result falls outside −32768..32767. Operands are read as two's complement, so bit 15 has weight −2^15. This holds in both modes.
- R6: A carry produced in a low section passes through every higher section whose bits all propagate. Examples: 0x0FFF + 0x0001 = 0x1000, 0x00FF + 0x0001 = 0x0100, 0xFFFF + 0x0001 = 0x0000 with `cout_o` = 1.
- R7: The outputs depend only on the present inputs. No clock and no stored state are involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 16 | First operand, two's complement |
| opb_i | input | 16 | Second operand, two's complement |
| sub_i | input | 1 | 0 selects opa_i + opb_i, 1 selects opa_i − opb_i |
| res_o | output | 16 | Result modulo 2^16 |
| cout_o | output | 1 | Carry out of bit 15 (1 means no borrow when subtracting) |
| ovf_o | output | 1 | Signed overflow of the result |

## Verification
The block holds no state, so an internal fault shows at the ports as soon as the inputs settle, in the same evaluation. One example is a section multiplexer steered by the wrong assumed carry. Another is a chain wired with the wrong constant carry. Such faults damage only the sum bits of one section, and only when that section receives a particular incoming carry. For this reason the stimulus targets operands that make carries cross every section boundary, in both modes and with both incoming carry values. The overflow flag reads the carry into the top bit, so a fault there appears only at the signed extremes. The bench therefore drives 0, −1, the most negative value and the most positive value against each other.

// File: rtl/csel_pkg.sv
package csel_pkg;

    // Default operand width and section width.
    parameter int CSEL_WIDTH = 16;
    parameter int CSEL_SEC_W = 4;

    // Arithmetic operation selected by the mode input.
    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;

endpackage

// File: rtl/csel_gp_unit.sv
// Per-bit generate, propagate and half-sum terms for one section.
module csel_gp_unit #(
    parameter int SEC_W = 4
) (
    input  logic [SEC_W-1:0] a_i,
    input  logic [SEC_W-1:0] b_i,
    output logic [SEC_W-1:0] gen_o,
    output logic [SEC_W-1:0] prop_o,
    output logic [SEC_W-1:0] hsum_o
);

    assign gen_o  = a_i & b_i;
    assign prop_o = a_i | b_i;
    assign hsum_o = a_i ^ b_i;

endmodule

// File: rtl/csel_chain.sv
// Ripple carry chain for one section, with a constant assumed carry-in.
module csel_chain #(
    parameter int SEC_W = 4,
    parameter bit CIN   = 1'b0
) (
    input  logic [SEC_W-1:0] gen_i,
    input  logic [SEC_W-1:0] prop_i,
    input  logic [SEC_W-1:0] hsum_i,
    output logic [SEC_W-1:0] sum_o,
    output logic             cout_o
);

    logic [SEC_W:0] carry;

    always_comb begin
        carry[0] = CIN;
        for (int i = 0; i < SEC_W; i++) begin
            carry[i+1] = gen_i[i] | (prop_i[i] & carry[i]);
        end
    end

    assign sum_o  = hsum_i ^ carry[SEC_W-1:0];
    assign cout_o = carry[SEC_W];

endmodule

// File: rtl/csel_section.sv
// One carry-select section: two speculative chains and a result multiplexer.
module csel_section #(
    parameter int SEC_W = 4
) (
    input  logic [SEC_W-1:0] a_i,
    input  logic [SEC_W-1:0] b_i,
    input  logic             cin_i,
    output logic [SEC_W-1:0] sum_o,
    output logic             cout_o
);

    localparam int NUM_SPEC = 2;

    logic [SEC_W-1:0] gen;
    logic [SEC_W-1:0] prop;
    logic [SEC_W-1:0] hsum;
    logic [SEC_W-1:0] spec_sum  [NUM_SPEC];
    logic             spec_cout [NUM_SPEC];

    csel_gp_unit #(
        .SEC_W (SEC_W)
    ) u_gp (
        .a_i    (a_i),
        .b_i    (b_i),
        .gen_o  (gen),
        .prop_o (prop),
        .hsum_o (hsum)
    );

    // Index 0 assumes an incoming carry of 0, index 1 assumes 1.
    for (genvar k = 0; k < NUM_SPEC; k++) begin : g_spec
        csel_chain #(
            .SEC_W (SEC_W),
            .CIN   (k == 1)
        ) u_chain (
            .gen_i  (gen),
            .prop_i (prop),
            .hsum_i (hsum),
            .sum_o  (spec_sum[k]),
            .cout_o (spec_cout[k])
        );
    end

    assign sum_o  = cin_i ? spec_sum[1]  : spec_sum[0];
    assign cout_o = cin_i ? spec_cout[1] : spec_cout[0];

endmodule

// File: rtl/csel_addsub.sv
// Combinational carry-select adder/subtractor. WIDTH must be a multiple of SEC_W.
module csel_addsub
    import csel_pkg::*;
#(
    parameter int WIDTH = CSEL_WIDTH,
    parameter int SEC_W = CSEL_SEC_W
) (
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] res_o,
    output logic             cout_o,
    output logic             ovf_o
);

    localparam int NUM_SEC = WIDTH / SEC_W;
    localparam int MSB     = WIDTH - 1;

    op_e              op;
    logic [WIDTH-1:0] opb_eff;
    logic [NUM_SEC:0] sec_carry;
    logic             carry_into_msb;

    assign op           = sub_i ? OP_SUB : OP_ADD;
    assign opb_eff      = (op == OP_SUB) ? ~opb_i : opb_i;
    assign sec_carry[0] = (op == OP_SUB);

    for (genvar s = 0; s < NUM_SEC; s++) begin : g_sec
        csel_section #(
            .SEC_W (SEC_W)
        ) u_section (
            .a_i    (opa_i[s*SEC_W +: SEC_W]),
            .b_i    (opb_eff[s*SEC_W +: SEC_W]),
            .cin_i  (sec_carry[s]),
            .sum_o  (res_o[s*SEC_W +: SEC_W]),
            .cout_o (sec_carry[s+1])
        );
    end

    // Recover the carry into the top bit from its sum bit.
    assign carry_into_msb = res_o[MSB] ^ opa_i[MSB] ^ opb_eff[MSB];
    assign cout_o         = sec_carry[NUM_SEC];
    assign ovf_o          = carry_into_msb ^ cout_o;

endmodule

// File: rtl/csel_addsub_chk.sv
// Checker with immediate assertions, bound to the adder/subtractor.
module csel_addsub_chk #(
    parameter int WIDTH = 16
) (
    input logic [WIDTH-1:0] opa_i,
    input logic [WIDTH-1:0] opb_i,
    input logic             sub_i,
    input logic [WIDTH-1:0] res_o,
    input logic             cout_o,
    input logic             ovf_o
);

    logic [WIDTH:0] ref_add;
    logic [WIDTH:0] ref_sub;
    logic [WIDTH:0] ref_sgn;
    logic           known;

    always_comb begin
        ref_add = {1'b0, opa_i} + {1'b0, opb_i};
        ref_sub = {1'b0, opa_i} - {1'b0, opb_i};
        ref_sgn = sub_i ? ({opa_i[WIDTH-1], opa_i} - {opb_i[WIDTH-1], opb_i})
                        : ({opa_i[WIDTH-1], opa_i} + {opb_i[WIDTH-1], opb_i});
        known   = !$isunknown({opa_i, opb_i, sub_i, res_o, cout_o, ovf_o});
        if (known) begin
            assert_add_sum_R1: assert (sub_i || res_o == ref_add[WIDTH-1:0])
                else $error("R1 add result mismatch");
            assert_sub_sum_R2: assert (!sub_i || res_o == ref_sub[WIDTH-1:0])
                else $error("R2 sub result mismatch");
            assert_add_cout_R3: assert (sub_i || cout_o == ref_add[WIDTH])
                else $error("R3 add carry mismatch");
            assert_sub_cout_R4: assert (!sub_i || cout_o == (opa_i >= opb_i))
                else $error("R4 sub carry mismatch");
            assert_ovf_R5: assert (ovf_o == (ref_sgn[WIDTH] != ref_sgn[WIDTH-1]))
                else $error("R5 overflow mismatch");
        end
    end

endmodule

bind csel_addsub csel_addsub_chk #(
    .WIDTH (WIDTH)
) u_chk (
    .opa_i  (opa_i),
    .opb_i  (opb_i),
    .sub_i  (sub_i),
    .res_o  (res_o),
    .cout_o (cout_o),
    .ovf_o  (ovf_o)
);

// File: tb/csel_addsub_tb.sv
`timescale 1ns/1ps
module csel_addsub_tb;

    localparam int W        = 16;
    localparam int WDOG_MAX = 100000;

    typedef struct {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic         sub;
        logic [W-1:0] exp_res;
        logic         exp_cout;
        logic         exp_ovf;
        string        tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic         sub = 1'b0;
    logic [W-1:0] res;
    logic         cout;
    logic         ovf;

    int    checks = 0;
    int    errors = 0;
    int    cyc    = 0;
    bit    done   = 1'b0;
    item_t sb_q[$];

    always #10 clk = ~clk;

    csel_addsub u_dut (
        .opa_i  (opa),
        .opb_i  (opb),
        .sub_i  (sub),
        .res_o  (res),
        .cout_o (cout),
        .ovf_o  (ovf)
    );

    // Driver: applies one operation and queues its expected result.
    task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic s, input string tag);
        item_t it;
        int    sa;
        int    sb;
        int    sr;
        @(posedge clk);
        #1;
        opa = a;
        opb = b;
        sub = s;
        sa  = $signed(a);
        sb  = $signed(b);
        sr  = s ? sa - sb : sa + sb;
        it.a   = a;
        it.b   = b;
        it.sub = s;
        if (s) begin
            it.exp_res  = W'(int'(a) - int'(b));
            it.exp_cout = (a >= b);                              // R4
        end else begin
            it.exp_res  = W'(int'(a) + int'(b));
            it.exp_cout = ((int'(a) + int'(b)) >= (1 << W));     // R3
        end
        it.exp_ovf = (sr > 32767) || (sr < -32768);              // R5
        it.tag     = tag;
        sb_q.push_back(it);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: compares the settled outputs away from the driving edge.
    always @(negedge clk) begin
        if (!rst && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            check(res == it.exp_res, it.tag, int'(res), int'(it.exp_res));
            check(cout == it.exp_cout, it.sub ? "R4" : "R3",
                  int'(cout), int'(it.exp_cout));
            check(ovf == it.exp_ovf, "R5", int'(ovf), int'(it.exp_ovf));
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG_MAX && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG_MAX);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] corner [4];
        corner[0] = 16'h0000;
        corner[1] = 16'hFFFF;
        corner[2] = 16'h8000;
        corner[3] = 16'h7FFF;

        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        // R7: all-zero inputs settle to a zero result, no carry, no overflow.
        #5;
        check(res == '0 && cout == 1'b0 && ovf == 1'b0, "R7",
              int'({res, cout, ovf}), 0);

        // R6: carries that cross one, two and three section boundaries.
        drive(16'h000F, 16'h0001, 1'b0, "R6");
        drive(16'h00FF, 16'h0001, 1'b0, "R6");
        drive(16'h0FFF, 16'h0001, 1'b0, "R6");
        drive(16'hFFFF, 16'h0001, 1'b0, "R6");
        drive(16'h1000, 16'h0001, 1'b1, "R6");
        drive(16'h0000, 16'h0001, 1'b1, "R6");
        drive(16'h0F0F, 16'h00F1, 1'b0, "R6");

        // R1, R2, R5: every pair of corner operands in both modes.
        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 4; j++) begin
                drive(corner[i], corner[j], 1'b0, "R1");
                drive(corner[i], corner[j], 1'b1, "R2");
            end
        end

        // R1, R2: random operands.
        for (int n = 0; n < 400; n++) begin
            logic [W-1:0] ra;
            logic [W-1:0] rb;
            ra = W'($urandom);
            rb = W'($urandom);
            drive(ra, rb, 1'b0, "R1");
            drive(ra, rb, 1'b1, "R2");
        end

        // R7: the same inputs again give the same outputs.
        drive(16'h1234, 16'h4321, 1'b0, "R7");
        drive(16'h1234, 16'h4321, 1'b0, "R7");

        while (sb_q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule